// File: doc/BRIEF.md
# Epoch Tag Conflict Classifier

This block sits next to the tag array of a private cache and decides, for every load or store, how the access relates to the persistence epoch recorded on the touched line. Each line may carry an epoch tag: a local epoch number, the identifier of the thread that wrote it and the identifier of the core that ran that thread. The cache looks up the line's tag and presents it together with the access and the core's running epoch. One clock later the block reports one of four outcomes:

- the line gets tagged;
- there is no conflict;
- the store hits a same-thread ordering hazard and must stall until the older epoch persists;
- the access creates a cross-thread dependency, in which case the block also tells the owning core to close its source epoch and open a new sub-epoch.

The block also drives the tag write port. It writes a new tag when a fresh line is first stored to, and it clears a tag when the cache reports that a dirty line has been written back and is now clean. The tag storage, coherence and data path are outside the block.

Top module: `epoch_tag_classifier`

## Requirements
- R1: While reset is high and in the cycle after it, `res_valid`, `split_req` and `tag_wr_en` are low and `res_kind` is 0.
- R2: A store to a line with no valid tag reports kind 1 (tag). It writes a valid tag at the access index holding the current epoch, thread and core, with `tag_wr_clear` low.
- R3: A load to a line with no valid tag reports kind 0 (none) and issues no tag write.
- R4: A store whose thread matches the tag's thread and whose epoch is numerically greater than the tag's epoch reports kind 2 (same-thread stall). The tag's epoch, thread and core appear on the source bus, and no tag write is issued.
- R5: An access by the tag's thread that is not covered by R4 reports kind 0, carries a zero source bus and issues no tag write. This covers a load with a newer epoch, any access with an equal epoch, and a store with an older epoch.
- R6: A load or store whose thread differs from a valid tag's thread reports kind 3 (cross-thread). The tag's fields appear on the source bus, and the tag is not rewritten.
- R7: `split_req` is high exactly when kind 3 is reported, and `src_core` names the core that owns the source epoch.
- R8: A writeback notice (`wb_valid`) issues a tag write at `wb_index` with `tag_wr_clear` high and zero tag fields.
- R9: When a writeback notice and an access arrive together, the clear takes the tag write port and the access is still classified.
- R10: Every result is a registered strobe one cycle after the access and lasts one cycle. Without an access there is no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_index | input | INDEX_W | Line index of the access |
| cur_epoch | input | EPOCH_W | Running local epoch of the core |
| cur_thread | input | THREAD_W | Thread running on the core |
| cur_core | input | CORE_W | Identifier of this core |
| tag_valid | input | 1 | Looked-up line carries a tag |
| tag_epoch | input | EPOCH_W | Tag local epoch |
| tag_thread | input | THREAD_W | Tag thread |
| tag_core | input | CORE_W | Tag core |
| wb_valid | input | 1 | Line became clean after writeback |
| wb_index | input | INDEX_W | Index of that line |
| res_valid | output | 1 | Result strobe |
| res_kind | output | 2 | 0 none, 1 tag, 2 same-thread, 3 cross-thread |
| src_epoch | output | EPOCH_W | Conflicting tag epoch (zero otherwise) |
| src_thread | output | THREAD_W | Conflicting tag thread |
| src_core | output | CORE_W | Core owning the source epoch |
| split_req | output | 1 | Close source epoch, open a sub-epoch |
| tag_wr_en | output | 1 | Tag write strobe |
| tag_wr_clear | output | 1 | 1 = invalidate tag |
| tag_wr_index | output | INDEX_W | Tag write index |
| tag_wr_epoch | output | EPOCH_W | Tag epoch to write |
| tag_wr_thread | output | THREAD_W | Tag thread to write |
| tag_wr_core | output | CORE_W | Tag core to write |

## Verification
The vector table crosses loads and stores with fresh lines, matching threads and foreign threads.

- Fresh-line entries separate tagging from a plain miss.
- Same-thread entries use newer, equal and older epochs, which separates the stall from a silent hit and shows that an inverted epoch compare would be caught.
- Foreign-thread entries include equal epoch numbers, so that a comparison made on the epoch alone cannot pass as a thread comparison.
- Directed cases cover a clear on its own, a clear colliding with a tagging store, and the single-cycle length of the strobe.

// File: rtl/epc_pkg.sv
package epc_pkg;
  typedef enum logic [1:0] {
    RES_NONE  = 2'd0,
    RES_TAG   = 2'd1,
    RES_SAME  = 2'd2,
    RES_CROSS = 2'd3
  } res_e;
endpackage

// File: rtl/epc_compare.sv
module epc_compare
  import epc_pkg::*;
#(
  parameter int EPOCH_W  = 8,
  parameter int THREAD_W = 4
) (
  input  logic                is_store,
  input  logic                tag_valid,
  input  logic [EPOCH_W-1:0]  tag_epoch,
  input  logic [THREAD_W-1:0] tag_thread,
  input  logic [EPOCH_W-1:0]  cur_epoch,
  input  logic [THREAD_W-1:0] cur_thread,
  output res_e                kind,
  output logic                hazard
);
  logic same_thr;
  logic newer;

  assign same_thr = (tag_thread == cur_thread);
  assign newer    = (cur_epoch > tag_epoch);

  always_comb begin
    kind = RES_NONE;
    if (!tag_valid) begin
      if (is_store) kind = RES_TAG;
    end else if (!same_thr) begin
      kind = RES_CROSS;
    end else if (is_store && newer) begin
      kind = RES_SAME;
    end
    hazard = (kind == RES_SAME) || (kind == RES_CROSS);
  end
endmodule

// File: rtl/epc_tagwr.sv
module epc_tagwr
  import epc_pkg::*;
#(
  parameter int EPOCH_W  = 8,
  parameter int THREAD_W = 4,
  parameter int CORE_W   = 2,
  parameter int INDEX_W  = 6
) (
  input  logic                acc_valid,
  input  res_e                kind,
  input  logic [INDEX_W-1:0]  acc_index,
  input  logic [EPOCH_W-1:0]  cur_epoch,
  input  logic [THREAD_W-1:0] cur_thread,
  input  logic [CORE_W-1:0]   cur_core,
  input  logic                wb_valid,
  input  logic [INDEX_W-1:0]  wb_index,
  output logic                wr_en,
  output logic                wr_clear,
  output logic [INDEX_W-1:0]  wr_index,
  output logic [EPOCH_W-1:0]  wr_epoch,
  output logic [THREAD_W-1:0] wr_thread,
  output logic [CORE_W-1:0]   wr_core
);
  always_comb begin
    wr_en     = 1'b0;
    wr_clear  = 1'b0;
    wr_index  = '0;
    wr_epoch  = '0;
    wr_thread = '0;
    wr_core   = '0;
    if (wb_valid) begin
      wr_en    = 1'b1;
      wr_clear = 1'b1;
      wr_index = wb_index;
    end else if (acc_valid && kind == RES_TAG) begin
      wr_en     = 1'b1;
      wr_index  = acc_index;
      wr_epoch  = cur_epoch;
      wr_thread = cur_thread;
      wr_core   = cur_core;
    end
  end
endmodule

// File: rtl/epoch_tag_classifier.sv
module epoch_tag_classifier
  import epc_pkg::*;
#(
  parameter int EPOCH_W  = 8,
  parameter int THREAD_W = 4,
  parameter int CORE_W   = 2,
  parameter int INDEX_W  = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                acc_valid,
  input  logic                acc_store,
  input  logic [INDEX_W-1:0]  acc_index,
  input  logic [EPOCH_W-1:0]  cur_epoch,
  input  logic [THREAD_W-1:0] cur_thread,
  input  logic [CORE_W-1:0]   cur_core,
  input  logic                tag_valid,
  input  logic [EPOCH_W-1:0]  tag_epoch,
  input  logic [THREAD_W-1:0] tag_thread,
  input  logic [CORE_W-1:0]   tag_core,
  input  logic                wb_valid,
  input  logic [INDEX_W-1:0]  wb_index,
  output logic                res_valid,
  output logic [1:0]          res_kind,
  output logic [EPOCH_W-1:0]  src_epoch,
  output logic [THREAD_W-1:0] src_thread,
  output logic [CORE_W-1:0]   src_core,
  output logic                split_req,
  output logic                tag_wr_en,
  output logic                tag_wr_clear,
  output logic [INDEX_W-1:0]  tag_wr_index,
  output logic [EPOCH_W-1:0]  tag_wr_epoch,
  output logic [THREAD_W-1:0] tag_wr_thread,
  output logic [CORE_W-1:0]   tag_wr_core
);
  res_e                kind;
  logic                hazard;
  logic                nx_en, nx_clear;
  logic [INDEX_W-1:0]  nx_index;
  logic [EPOCH_W-1:0]  nx_epoch;
  logic [THREAD_W-1:0] nx_thread;
  logic [CORE_W-1:0]   nx_core;

  epc_compare #(.EPOCH_W(EPOCH_W), .THREAD_W(THREAD_W)) u_cmp (
    .is_store  (acc_store),
    .tag_valid (tag_valid),
    .tag_epoch (tag_epoch),
    .tag_thread(tag_thread),
    .cur_epoch (cur_epoch),
    .cur_thread(cur_thread),
    .kind      (kind),
    .hazard    (hazard)
  );

  epc_tagwr #(.EPOCH_W(EPOCH_W), .THREAD_W(THREAD_W),
              .CORE_W(CORE_W), .INDEX_W(INDEX_W)) u_wr (
    .acc_valid (acc_valid),
    .kind      (kind),
    .acc_index (acc_index),
    .cur_epoch (cur_epoch),
    .cur_thread(cur_thread),
    .cur_core  (cur_core),
    .wb_valid  (wb_valid),
    .wb_index  (wb_index),
    .wr_en     (nx_en),
    .wr_clear  (nx_clear),
    .wr_index  (nx_index),
    .wr_epoch  (nx_epoch),
    .wr_thread (nx_thread),
    .wr_core   (nx_core)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid     <= 1'b0;
      res_kind      <= '0;
      src_epoch     <= '0;
      src_thread    <= '0;
      src_core      <= '0;
      split_req     <= 1'b0;
      tag_wr_en     <= 1'b0;
      tag_wr_clear  <= 1'b0;
      tag_wr_index  <= '0;
      tag_wr_epoch  <= '0;
      tag_wr_thread <= '0;
      tag_wr_core   <= '0;
    end else begin
      res_valid  <= acc_valid;
      res_kind   <= acc_valid ? 2'(kind) : 2'd0;
      split_req  <= acc_valid && (kind == RES_CROSS);
      src_epoch  <= (acc_valid && hazard) ? tag_epoch  : '0;
      src_thread <= (acc_valid && hazard) ? tag_thread : '0;
      src_core   <= (acc_valid && hazard) ? tag_core   : '0;
      tag_wr_en     <= nx_en;
      tag_wr_clear  <= nx_clear;
      tag_wr_index  <= nx_index;
      tag_wr_epoch  <= nx_epoch;
      tag_wr_thread <= nx_thread;
      tag_wr_core   <= nx_core;
    end
  end
endmodule

// File: rtl/epc_checker.sv
module epc_checker #(
  parameter int EPOCH_W  = 8,
  parameter int THREAD_W = 4,
  parameter int CORE_W   = 2,
  parameter int INDEX_W  = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                acc_valid,
  input logic                acc_store,
  input logic [EPOCH_W-1:0]  cur_epoch,
  input logic                tag_valid,
  input logic [THREAD_W-1:0] tag_thread,
  input logic [THREAD_W-1:0] cur_thread,
  input logic                wb_valid,
  input logic [INDEX_W-1:0]  wb_index,
  input logic                res_valid,
  input logic [1:0]          res_kind,
  input logic                split_req,
  input logic                tag_wr_en,
  input logic                tag_wr_clear,
  input logic [INDEX_W-1:0]  tag_wr_index,
  input logic [EPOCH_W-1:0]  tag_wr_epoch
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !res_valid && !tag_wr_en); // R1
  AST_FRESH_STORE_TAGS: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_store && !tag_valid && !wb_valid |=>
      tag_wr_en && !tag_wr_clear && tag_wr_epoch == $past(cur_epoch)); // R2
  AST_SAME_ONLY_STORE: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !acc_store |=> res_kind != 2'd2); // R4
  AST_FOREIGN_CROSS: assert property (@(posedge clk) disable iff (rst)
    acc_valid && tag_valid && tag_thread != cur_thread |=> res_kind == 2'd3); // R6
  AST_SPLIT_WITH_CROSS: assert property (@(posedge clk) disable iff (rst)
    split_req |-> res_valid && res_kind == 2'd3); // R7
  AST_WB_CLEARS: assert property (@(posedge clk) disable iff (rst)
    wb_valid |=> tag_wr_en && tag_wr_clear && tag_wr_index == $past(wb_index)); // R8
  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> res_valid); // R10
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !res_valid); // R10
endmodule

bind epoch_tag_classifier epc_checker #(
  .EPOCH_W(EPOCH_W), .THREAD_W(THREAD_W), .CORE_W(CORE_W), .INDEX_W(INDEX_W)
) u_chk (.*);

// File: tb/epoch_tag_classifier_test.sv
module epoch_tag_classifier_test;
  localparam int EW = 8, TW = 4, CW = 2, IW = 6;

  typedef struct packed {
    logic          st;
    logic          tv;
    logic [EW-1:0] te;
    logic [TW-1:0] tt;
    logic [CW-1:0] tc;
    logic [EW-1:0] ce;
    logic [TW-1:0] ct;
    logic [CW-1:0] cc;
    logic [1:0]    kind;
    logic          wr;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 8'd0, 4'd0, 2'd0, 8'd3,   4'd2,  2'd1, 2'd1, 1'b1}, // R2
    '{1'b0, 1'b0, 8'd0, 4'd0, 2'd0, 8'd3,   4'd2,  2'd1, 2'd0, 1'b0}, // R3
    '{1'b1, 1'b1, 8'd5, 4'd3, 2'd1, 8'd7,   4'd3,  2'd2, 2'd2, 1'b0}, // R4
    '{1'b0, 1'b1, 8'd5, 4'd3, 2'd1, 8'd7,   4'd3,  2'd2, 2'd0, 1'b0}, // R5
    '{1'b1, 1'b1, 8'd7, 4'd3, 2'd1, 8'd7,   4'd3,  2'd2, 2'd0, 1'b0}, // R5
    '{1'b0, 1'b1, 8'd4, 4'd2, 2'd3, 8'd9,   4'd5,  2'd0, 2'd3, 1'b0}, // R6
    '{1'b1, 1'b1, 8'd4, 4'd2, 2'd3, 8'd9,   4'd5,  2'd0, 2'd3, 1'b0}, // R6
    '{1'b1, 1'b1, 8'd9, 4'd3, 2'd1, 8'd4,   4'd3,  2'd2, 2'd0, 1'b0}, // R5
    '{1'b1, 1'b1, 8'd6, 4'd1, 2'd2, 8'd6,   4'd2,  2'd0, 2'd3, 1'b0}, // R6
    '{1'b1, 1'b0, 8'd0, 4'd0, 2'd0, 8'd255, 4'd15, 2'd3, 2'd1, 1'b1}  // R2
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          acc_valid = 1'b0, acc_store = 1'b0;
  logic [IW-1:0] acc_index = '0;
  logic [EW-1:0] cur_epoch = '0;
  logic [TW-1:0] cur_thread = '0;
  logic [CW-1:0] cur_core = '0;
  logic          tag_valid = 1'b0;
  logic [EW-1:0] tag_epoch = '0;
  logic [TW-1:0] tag_thread = '0;
  logic [CW-1:0] tag_core = '0;
  logic          wb_valid = 1'b0;
  logic [IW-1:0] wb_index = '0;
  logic          res_valid, split_req, tag_wr_en, tag_wr_clear;
  logic [1:0]    res_kind;
  logic [EW-1:0] src_epoch, tag_wr_epoch;
  logic [TW-1:0] src_thread, tag_wr_thread;
  logic [CW-1:0] src_core, tag_wr_core;
  logic [IW-1:0] tag_wr_index;

  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  epoch_tag_classifier #(.EPOCH_W(EW), .THREAD_W(TW), .CORE_W(CW), .INDEX_W(IW)) uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_store(acc_store),
    .acc_index(acc_index), .cur_epoch(cur_epoch), .cur_thread(cur_thread),
    .cur_core(cur_core), .tag_valid(tag_valid), .tag_epoch(tag_epoch),
    .tag_thread(tag_thread), .tag_core(tag_core), .wb_valid(wb_valid),
    .wb_index(wb_index), .res_valid(res_valid), .res_kind(res_kind),
    .src_epoch(src_epoch), .src_thread(src_thread), .src_core(src_core),
    .split_req(split_req), .tag_wr_en(tag_wr_en), .tag_wr_clear(tag_wr_clear),
    .tag_wr_index(tag_wr_index), .tag_wr_epoch(tag_wr_epoch),
    .tag_wr_thread(tag_wr_thread), .tag_wr_core(tag_wr_core)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    acc_valid = 1'b0;
    wb_valid  = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    step();
    step();
    // R1: outputs quiet under reset
    chk("R1", "res_valid", 32'(res_valid), 0);
    chk("R1", "split_req", 32'(split_req), 0);
    chk("R1", "tag_wr_en", 32'(tag_wr_en), 0);
    chk("R1", "res_kind", 32'(res_kind), 0);
    rst = 1'b0;
    step();
    chk("R1", "res_valid after release", 32'(res_valid), 0);

    // Table walk: R2..R7, R10
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic haz;
      v = VEC[i];
      acc_valid  = 1'b1;
      acc_store  = v.st;
      acc_index  = IW'(i + 5);
      tag_valid  = v.tv;
      tag_epoch  = v.te;
      tag_thread = v.tt;
      tag_core   = v.tc;
      cur_epoch  = v.ce;
      cur_thread = v.ct;
      cur_core   = v.cc;
      step();
      idle_inputs();
      haz = (v.kind == 2'd2) || (v.kind == 2'd3);
      chk("R10", "res_valid", 32'(res_valid), 1);
      chk(v.kind == 2'd3 ? "R6" : v.kind == 2'd2 ? "R4" : v.kind == 2'd1 ? "R2" : "R5",
          "res_kind", 32'(res_kind), 32'(v.kind));
      chk("R7", "split_req", 32'(split_req), 32'(v.kind == 2'd3));
      chk("R6", "src_epoch", 32'(src_epoch), haz ? 32'(v.te) : 0);
      chk("R6", "src_thread", 32'(src_thread), haz ? 32'(v.tt) : 0);
      chk("R7", "src_core", 32'(src_core), haz ? 32'(v.tc) : 0);
      chk(v.wr ? "R2" : "R3", "tag_wr_en", 32'(tag_wr_en), 32'(v.wr));
      if (v.wr) begin
        chk("R2", "tag_wr_clear", 32'(tag_wr_clear), 0);
        chk("R2", "tag_wr_index", 32'(tag_wr_index), 32'(i + 5));
        chk("R2", "tag_wr_epoch", 32'(tag_wr_epoch), 32'(v.ce));
        chk("R2", "tag_wr_thread", 32'(tag_wr_thread), 32'(v.ct));
        chk("R2", "tag_wr_core", 32'(tag_wr_core), 32'(v.cc));
      end
      step();
      // R10: the strobe lasts a single cycle
      chk("R10", "res_valid drop", 32'(res_valid), 0);
      chk("R10", "split_req drop", 32'(split_req), 0);
    end

    // R8: writeback clears the tag
    wb_valid = 1'b1;
    wb_index = 6'd33;
    step();
    idle_inputs();
    chk("R8", "tag_wr_en", 32'(tag_wr_en), 1);
    chk("R8", "tag_wr_clear", 32'(tag_wr_clear), 1);
    chk("R8", "tag_wr_index", 32'(tag_wr_index), 33);
    chk("R8", "tag_wr_epoch", 32'(tag_wr_epoch), 0);
    chk("R10", "no strobe on clear only", 32'(res_valid), 0);

    // R9: clear collides with a tagging store
    wb_valid   = 1'b1;
    wb_index   = 6'd12;
    acc_valid  = 1'b1;
    acc_store  = 1'b1;
    acc_index  = 6'd40;
    tag_valid  = 1'b0;
    cur_epoch  = 8'd21;
    cur_thread = 4'd6;
    cur_core   = 2'd2;
    step();
    idle_inputs();
    chk("R9", "tag_wr_clear", 32'(tag_wr_clear), 1);
    chk("R9", "tag_wr_index", 32'(tag_wr_index), 12);
    chk("R9", "res_valid", 32'(res_valid), 1);
    chk("R9", "res_kind", 32'(res_kind), 1);
    step();
    chk("R9", "tag_wr_en idle", 32'(tag_wr_en), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule